// File: doc/BRIEF.md
# Write-Engine Busy Status Generator

This block models the busy period of a flash-style write engine and the data a host sees when it reads while that engine is running. A command decoder upstream hands it a one-cycle start pulse together with an operation code, a word address and a data word. The block then stays busy for a number of clock cycles fixed per operation, and at the end of that time it updates a small word array. A program can only clear bits of a word, a sector erase sets one sector to all ones, and a chip erase sets the whole array to all ones.

While the engine is busy, any read strobe returns a status word in place of array data. Bit 7 is a polling bit: it is the inverse of bit 7 of the word being programmed, or 0 during an erase. Bit 6 is a toggle bit that flips on each read strobe. All other status bits are 0. Once the operation has finished, reads return the array contents again. Durations are parameters in clock cycles, so short defaults keep simulation quick.

Top module: `wbusy_top`

## Requirements
- R1: A start pulse with operation code 0 (program), 1 (sector erase) or 2 (chip erase), given while `busy_o` is low, sets `busy_o` from the next clock edge. `busy_o` then stays high for exactly PROG_CYC, SERASE_CYC or CERASE_CYC cycles respectively.
- R2: When a program finishes, the addressed word becomes its previous value AND the supplied data. Programming never sets a bit.
- R3: When a sector erase finishes, every word whose top SECT_W address bits match those of the supplied address reads 0xFFFF, and all other words are unchanged. When a chip erase finishes, every word reads 0xFFFF.
- R4: A status read during a program returns the inverse of bit 7 of the programmed data in bit 7. A status read during a sector or chip erase returns 0 in bit 7.
- R5: Bit 6 of status reads starts at 0 on the first read after a start and inverts on every later read strobe during the busy period. Cycles without a read strobe do not change it.
- R6: In a status read, every bit other than bits 7 and 6 is 0.
- R7: A start pulse given while `busy_o` is high is ignored. The running operation keeps its length and its result, and the ignored request changes no word.
- R8: `rd_i` is sampled at a clock edge, and `rdata_o` takes its new value at that same edge. If `busy_o` was high in that cycle, the new value is the status word; otherwise it is the array word at `rd_addr_i`. With no read strobe, `rdata_o` holds its value.
- R9: After reset, `busy_o` and `rdata_o` are 0 and every word of the array reads 0xFFFF.
- R10: A start pulse with operation code 3 is ignored: `busy_o` stays low and no word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_i | input | 2 | Operation code: 0 program, 1 sector erase, 2 chip erase, 3 none |
| addr_i | input | ADDR_W | Target word address; its top SECT_W bits select the sector |
| wdata_i | input | DATA_W | Data word for a program |
| rd_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Address of the read |
| rdata_o | output | DATA_W | Registered read result or status word |
| busy_o | output | 1 | High while an operation runs |

## Verification
`busy_o` rises at the first edge after an accepted start, and it falls at the edge that ends cycle PROG_CYC, SERASE_CYC or CERASE_CYC of the busy period. The bench counts busy cycles at falling edges and compares the count with the expected duration. A read result is due at the edge that samples the strobe, so the bench drives the strobe at a falling edge and compares `rdata_o` at the next falling edge. The reference model decides between status and array data from the `busy_o` value it saw when it drove the strobe. Array effects are checked by reads issued only after `busy_o` has been seen low, and a no-strobe cycle afterwards confirms that the output holds.

// File: rtl/wbusy_pkg.sv
package wbusy_pkg;

    typedef enum logic [1:0] {
        OP_PROG   = 2'd0,
        OP_SERASE = 2'd1,
        OP_CERASE = 2'd2,
        OP_NONE   = 2'd3
    } wop_e;

    // bit 7 of a status word: inverted write data on program, 0 on erase
    function automatic logic poll_bit(wop_e op, logic wd7);
        return (op == OP_PROG) ? ~wd7 : 1'b0;
    endfunction

    function automatic logic op_valid(wop_e op);
        return op != OP_NONE;
    endfunction

endpackage

// File: rtl/wbusy_timer.sv
module wbusy_timer
    import wbusy_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int PROG_CYC   = 6,
    parameter int SERASE_CYC = 24,
    parameter int CERASE_CYC = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  wop_e op_i,
    output logic accept_o,
    output logic done_o,
    output logic busy_o,
    output wop_e op_q
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] dur;

    always_comb begin
        case (op_i)
            OP_SERASE: dur = CNT_W'(SERASE_CYC);
            OP_CERASE: dur = CNT_W'(CERASE_CYC);
            default:   dur = CNT_W'(PROG_CYC);
        endcase
    end

    assign accept_o = start_i && !busy_o && op_valid(op_i);
    assign done_o   = busy_o && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            cnt    <= '0;
            op_q   <= OP_PROG;
        end else if (accept_o) begin
            busy_o <= 1'b1;
            cnt    <= dur - CNT_W'(1);
            op_q   <= op_i;
        end else if (busy_o) begin
            if (cnt == '0) busy_o <= 1'b0;
            else           cnt    <= cnt - CNT_W'(1);
        end
    end

    p_accept_busy_r1: assert property (@(posedge clk) disable iff (rst)
        start_i && !busy_o && op_i != OP_NONE |=> busy_o);

    p_busy_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        busy_o && start_i |=> $stable(op_q));

    p_none_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        start_i && !busy_o && op_i == OP_NONE |=> !busy_o);

endmodule

// File: rtl/wbusy_array.sv
module wbusy_array
    import wbusy_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done_i,
    input  wop_e              op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] word_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    function automatic logic [SECT_W-1:0] sect_of(logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: SECT_W];
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (done_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                case (op_i)
                    OP_PROG:
                        if (ADDR_W'(i) == addr_i) mem[i] <= mem[i] & data_i;
                    OP_SERASE:
                        if (sect_of(ADDR_W'(i)) == sect_of(addr_i)) mem[i] <= '1;
                    OP_CERASE:
                        mem[i] <= '1;
                    default: ;
                endcase
            end
        end
    end

    assign word_o = mem[rd_addr_i];

    p_prog_no_set_r2: assert property (@(posedge clk) disable iff (rst)
        done_i && op_i == OP_PROG |=>
        ((mem[$past(addr_i)] & ~$past(mem[addr_i])) == '0));

    p_erase_ones_r3: assert property (@(posedge clk) disable iff (rst)
        done_i && op_i != OP_PROG |=> (mem[$past(addr_i)] == '1));

endmodule

// File: rtl/wbusy_status.sv
module wbusy_status
    import wbusy_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic              busy_i,
    input  wop_e              op_i,
    input  logic              wd7_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam logic [DATA_W-1:0] STAT_MASK = DATA_W'(8'hC0);

    logic              tog;
    logic [DATA_W-1:0] stat_word;

    always_comb begin
        stat_word    = '0;
        stat_word[7] = poll_bit(op_i, wd7_i);
        stat_word[6] = tog;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tog     <= 1'b0;
            rdata_o <= '0;
        end else begin
            if (accept_i)            tog <= 1'b0;
            else if (rd_i && busy_i) tog <= ~tog;
            if (rd_i) rdata_o <= busy_i ? stat_word : word_i;
        end
    end

    p_toggle_flip_r5: assert property (@(posedge clk) disable iff (rst)
        rd_i && busy_i |=> tog != $past(tog));

    p_toggle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !rd_i && !accept_i |=> $stable(tog));

    p_status_zero_r6: assert property (@(posedge clk) disable iff (rst)
        rd_i && busy_i |=> ((rdata_o & ~STAT_MASK) == '0));

    p_erase_poll_r4: assert property (@(posedge clk) disable iff (rst)
        rd_i && busy_i && op_i != OP_PROG |=> !rdata_o[7]);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !rd_i |=> $stable(rdata_o));

endmodule

// File: rtl/wbusy_top.sv
module wbusy_top
    import wbusy_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int SECT_W     = 3,
    parameter int PROG_CYC   = 6,
    parameter int SERASE_CYC = 24,
    parameter int CERASE_CYC = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              busy_o
);
    localparam int MAX_A   = (PROG_CYC > SERASE_CYC) ? PROG_CYC : SERASE_CYC;
    localparam int MAX_CYC = (MAX_A > CERASE_CYC) ? MAX_A : CERASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    wop_e              op_in;
    wop_e              op_q;
    logic              accept;
    logic              done;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] word;

    assign op_in = wop_e'(op_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '1;
        end else if (accept) begin
            addr_q <= addr_i;
            data_q <= wdata_i;
        end
    end

    wbusy_timer #(
        .CNT_W(CNT_W), .PROG_CYC(PROG_CYC),
        .SERASE_CYC(SERASE_CYC), .CERASE_CYC(CERASE_CYC)
    ) u_timer (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_in),
        .accept_o(accept), .done_o(done), .busy_o(busy_o), .op_q(op_q)
    );

    wbusy_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_array (
        .clk(clk), .rst(rst), .done_i(done), .op_i(op_q),
        .addr_i(addr_q), .data_i(data_q), .rd_addr_i(rd_addr_i), .word_o(word)
    );

    wbusy_status #(.DATA_W(DATA_W)) u_status (
        .clk(clk), .rst(rst), .accept_i(accept), .busy_i(busy_o),
        .op_i(op_q), .wd7_i(data_q[7]), .rd_i(rd_i),
        .word_i(word), .rdata_o(rdata_o)
    );

    p_addr_held_r7: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(addr_q) && $stable(data_q));

endmodule

// File: tb/wbusy_top_tb.sv
module wbusy_top_tb;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int SECT_W = 3;
    localparam int PCYC = 6, SCYC = 24, CCYC = 40;
    localparam int DEPTH = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst;
    logic              start_i;
    logic [1:0]        op_i;
    logic [ADDR_W-1:0] addr_i;
    logic [DATA_W-1:0] wdata_i;
    logic              rd_i;
    logic [ADDR_W-1:0] rd_addr_i;
    logic [DATA_W-1:0] rdata_o;
    logic              busy_o;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [DATA_W-1:0] model [DEPTH];

    always #10 clk = ~clk;

    wbusy_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W),
        .PROG_CYC(PCYC), .SERASE_CYC(SCYC), .CERASE_CYC(CCYC)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rd_i(rd_i), .rd_addr_i(rd_addr_i),
        .rdata_o(rdata_o), .busy_o(busy_o));

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int dur_of(logic [1:0] op);
        return (op == 2'd0) ? PCYC : (op == 2'd1) ? SCYC : CCYC;
    endfunction

    function automatic logic [DATA_W-1:0] status_of(logic [1:0] op,
            logic [DATA_W-1:0] d, bit tog);
        logic [DATA_W-1:0] s = '0;
        s[7] = (op == 2'd0) ? ~d[7] : 1'b0;
        s[6] = tog;
        return s;
    endfunction

    task automatic apply_model(logic [1:0] op, logic [ADDR_W-1:0] a,
            logic [DATA_W-1:0] d);
        for (int i = 0; i < DEPTH; i++) begin
            if (op == 2'd0 && i == int'(a)) model[i] = model[i] & d;
            if (op == 2'd1 && ADDR_W'(i) >> (ADDR_W - SECT_W) == a >> (ADDR_W - SECT_W))
                model[i] = '1;
            if (op == 2'd2) model[i] = '1;
        end
    endtask

    // read one word when idle, then confirm it holds without a strobe (R8)
    task automatic read_check(logic [ADDR_W-1:0] a, string req);
        rd_i = 1'b1; rd_addr_i = a;
        @(negedge clk);
        rd_i = 1'b0; rd_addr_i = ~a;
        check(rdata_o == model[a], req, 32'(rdata_o), 32'(model[a]));
        @(negedge clk);
        check(rdata_o == model[a], "R8 hold", 32'(rdata_o), 32'(model[a]));
    endtask

    // run one operation, reading status at random cycles; optionally poke a
    // second start while busy (R7)
    task automatic run_op(logic [1:0] op, logic [ADDR_W-1:0] a,
            logic [DATA_W-1:0] d, bit poke);
        int cycles = 0;
        bit tog = 0;
        start_i = 1'b1; op_i = op; addr_i = a; wdata_i = d;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R1 busy rise", 32'(busy_o), 32'd1);
        while (busy_o && cycles < 200) begin
            bit r = 1'($urandom % 2);
            cycles++;
            if (poke && cycles == 2) begin
                start_i = 1'b1; op_i = 2'd2; addr_i = ~a; wdata_i = 16'h0000;
            end
            rd_i = r; rd_addr_i = ADDR_W'($urandom);
            @(negedge clk);
            start_i = 1'b0; rd_i = 1'b0;
            if (r) begin
                logic [DATA_W-1:0] e = status_of(op, d, tog);
                check(rdata_o == e, "R4/R5/R6 status", 32'(rdata_o), 32'(e));
                tog = ~tog;
            end
        end
        check(cycles == dur_of(op), poke ? "R7 length kept" : "R1 busy length",
              32'(cycles), 32'(dur_of(op)));
        apply_model(op, a, d);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd12345));
        for (int i = 0; i < DEPTH; i++) model[i] = '1;
        rst = 1'b1; start_i = 0; op_i = 0; addr_i = 0; wdata_i = 0;
        rd_i = 0; rd_addr_i = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(busy_o == 0, "R9 busy reset", 32'(busy_o), 0);
        check(rdata_o == 0, "R9 rdata reset", 32'(rdata_o), 0);
        read_check(8'd5, "R9 erased array");

        // operation code 3 is ignored (R10)
        start_i = 1; op_i = 2'd3; addr_i = 8'd5; wdata_i = 16'h0;
        @(negedge clk);
        start_i = 0;
        check(busy_o == 0, "R10 none ignored", 32'(busy_o), 0);
        read_check(8'd5, "R10 no change");

        // directed program: bit 7 set and cleared, then AND behaviour (R2, R4)
        run_op(2'd0, 8'd10, 16'h1234, 0);
        read_check(8'd10, "R2 program");
        run_op(2'd0, 8'd10, 16'hFF80, 0);
        read_check(8'd10, "R2 only clears");
        run_op(2'd0, 8'd40, 16'h00A5, 1);
        read_check(8'd40, "R7 ignored start");
        read_check(8'd41, "R7 no chip erase");
        // sector erase of sector 0 leaves sector 1 (R3)
        run_op(2'd1, 8'd3, 16'h0, 0);
        read_check(8'd10, "R3 sector erased");
        read_check(8'd40, "R3 other sector kept");
        run_op(2'd2, 8'd0, 16'h0, 0);
        read_check(8'd40, "R3 chip erase");

        // random mix
        for (int k = 0; k < 40; k++) begin
            logic [1:0] op = ($urandom % 8 == 0) ? 2'd1 :
                             ($urandom % 16 == 0) ? 2'd2 : 2'd0;
            logic [ADDR_W-1:0] a = ADDR_W'($urandom);
            run_op(op, a, DATA_W'($urandom), 1'($urandom % 4 == 0));
            read_check(a, "R2/R3 random target");
            read_check(ADDR_W'($urandom), "R2/R3 random other");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule